// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block produces a clock at sixteen times a selected serial bit rate for a UART-style link. It runs from a single system clock. The reference is carried as a one-cycle "master tick" enable and is never used as a derived clock. With the nominal 2.4576 MHz reference the outputs land on standard bit rates. A slower reference scales every rate down in proportion.

The master tick comes from one of two places. In primary mode it is the `pri_tick` enable input. In alternate mode it is each rising edge of the level input `alt_clk`. A 3-bit scan counter advances on every master tick. Its wrap feeds a binary divider chain and two further dividers. Two more dividers run directly on the master tick. Among them these produce thirteen rates. A 4-bit select chooses one rate, or the pass-through input. The choice is re-registered on the master tick and drives `rate_out`.

The scan counter and a registered copy of the master tick are brought out. They can be fed back to the selects to scan several rates in turn. An initializer clears every counter on the first high level of `alt_clk` after alternate mode is entered. It holds the counters clear whenever `alt_clk` is high in primary mode.

Top module: `bclk_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `scan_out` is 0, `mclk_out` is 0 and `rate_out` is 0.
- R2: In primary mode (`use_primary`=1), a high `pri_tick` at a clock edge is a master tick. It sets `mclk_out` to 1 and advances `scan_out` by one, modulo 8, at that edge. Without a tick, `mclk_out` is 0 and `scan_out` holds.
- R3: Select codes 0 and 1 pass `pass_in` through. `rate_out` takes the value of `pass_in` at each master tick.
- R4: `rate_out` is registered. It changes only at a clock edge carrying a master tick (or a clear), so `rate_sel` and `pass_in` have no effect between ticks.
- R5: Codes 2 to 15 select, in order: 50, 75, 134.5, 200, 600, 2400, 9600, 4800, 1800, 1200, 2400, 300, 150 and 110 baud. The `rate_out` period in master ticks is within 0.5% of 153600 divided by the bit rate.
- R6: For every selected rate, the high and low times of one `rate_out` period differ by at most one master tick. The 1800-baud output spans exactly 256 master ticks over any three periods.
- R7: At code 8 (9600 baud) a `rate_out` period is exactly 16 master ticks. This is two full passes of the scan counter, one per half-period.
- R8: In primary mode, `alt_clk` high holds all counters clear. `scan_out`, `mclk_out` and `rate_out` stay 0 even when `pri_tick` is high. Ticks resume from the second clock after `alt_clk` returns low.
- R9: In alternate mode (`use_primary`=0), `pri_tick` is ignored. The first high level of `alt_clk` clears all counters once, without counting. Each later low-to-high change of `alt_clk` is one master tick, effective at the second clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| use_primary | input | 1 | 1: ticks from `pri_tick`; 0: ticks from `alt_clk` edges |
| pri_tick | input | 1 | Primary reference enable, one pulse per reference cycle |
| alt_clk | input | 1 | Alternate reference level, sampled by `clk` |
| pass_in | input | 1 | Pass-through input for select codes 0 and 1 |
| rate_sel | input | 4 | Rate select code |
| rate_out | output | 1 | Registered 16x bit-rate clock |
| mclk_out | output | 1 | Registered master-tick pulse |
| scan_out | output | 3 | Scan counter state |

## Verification
The properties assume that `alt_clk`, `use_primary`, `pri_tick`, `rate_sel` and `pass_in` are synchronous to `clk`. They also assume that `alt_clk` stays low in primary mode except when a hold-clear is intended. The stimulus changes every input on the falling edge and samples on the next falling edge. It holds `alt_clk` low for all rate measurements and raises it only in the directed hold-clear and alternate-mode checks. It keeps `pri_tick` high for rate measurements, so that clock cycles equal master ticks.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int SCAN_W  = 3;
  localparam int CHAIN_W = 8;
  // odd-ratio dividers: half-period length and whether they count scan wraps (1) or master ticks (0)
  localparam int NDIV = 4;
  localparam int unsigned DIV_HALF [NDIV] = '{192, 48, 698, 571};
  localparam bit          DIV_SCAN [NDIV] = '{1'b1, 1'b1, 1'b0, 1'b0};
  // fractional divider: GROUP half-periods, the last one SHORT, the rest LONG
  localparam int FRAC_LONG  = 43;
  localparam int FRAC_SHORT = 42;
  localparam int FRAC_GROUP = 3;

  typedef enum logic [3:0] {
    SEL_PASS0 = 4'd0,  SEL_PASS1 = 4'd1,  SEL_B50   = 4'd2,  SEL_B75   = 4'd3,
    SEL_B134  = 4'd4,  SEL_B200  = 4'd5,  SEL_B600  = 4'd6,  SEL_B2400 = 4'd7,
    SEL_B9600 = 4'd8,  SEL_B4800 = 4'd9,  SEL_B1800 = 4'd10, SEL_B1200 = 4'd11,
    SEL_B2400B = 4'd12, SEL_B300 = 4'd13, SEL_B150  = 4'd14, SEL_B110  = 4'd15
  } rate_sel_e;
endpackage

// File: rtl/bclk_init.sv
module bclk_init (
  input  logic clk,
  input  logic rst,
  input  logic use_primary,
  input  logic pri_tick,
  input  logic alt_clk,
  output logic tick,
  output logic clear,
  output logic alt_level
);
  logic alt_q, alt_p, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_q <= 1'b0;
      alt_p <= 1'b0;
      armed <= 1'b0;
    end else begin
      alt_q <= alt_clk;
      alt_p <= alt_q;
      if (use_primary)  armed <= 1'b1;
      else if (alt_q)   armed <= 1'b0;
    end
  end

  // continuous hold in primary mode, one-shot clear on the first high in alternate mode
  assign clear     = rst | (alt_q & (use_primary | armed));
  assign tick      = ~clear & (use_primary ? pri_tick : (alt_q & ~alt_p));
  assign alt_level = alt_q;

  // R9
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_primary && $past(!use_primary) && alt_q && !armed) |-> !clear);
endmodule

// File: rtl/bclk_scan.sv
module bclk_scan #(
  parameter int SCAN_W  = 3,
  parameter int CHAIN_W = 8
) (
  input  logic               clk,
  input  logic               clear,
  input  logic               tick,
  output logic [SCAN_W-1:0]  scan_q,
  output logic [CHAIN_W-1:0] chain_q,
  output logic               wrap_tick
);
  localparam logic [SCAN_W-1:0] SCAN_LAST = '1;

  assign wrap_tick = tick & (scan_q == SCAN_LAST);

  always_ff @(posedge clk) begin
    if (clear) begin
      scan_q  <= '0;
      chain_q <= '0;
    end else begin
      if (tick)      scan_q  <= scan_q + 1'b1;
      if (wrap_tick) chain_q <= chain_q + 1'b1;
    end
  end

  // R7
  chain_step_chk: assert property (@(posedge clk) disable iff (clear)
    !wrap_tick |=> $stable(chain_q));
endmodule

// File: rtl/bclk_toggle.sv
module bclk_toggle #(
  parameter int unsigned HALF = 48
) (
  input  logic clk,
  input  logic clear,
  input  logic en,
  output logic q
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (en) begin
      if (cnt == LAST) begin
        cnt <= '0;
        q   <= ~q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (clear)
    cnt <= LAST);
endmodule

// File: rtl/bclk_frac.sv
module bclk_frac #(
  parameter int LONG  = 43,
  parameter int SHORT = 42,
  parameter int GROUP = 3
) (
  input  logic clk,
  input  logic clear,
  input  logic en,
  output logic q
);
  localparam int CW = $clog2(LONG);
  localparam int PW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(GROUP - 1);

  logic [CW-1:0] cnt, lim;
  logic [PW-1:0] ph;

  assign lim = (ph == PH_LAST) ? CW'(SHORT - 1) : CW'(LONG - 1);

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
      ph  <= '0;
      q   <= 1'b0;
    end else if (en) begin
      if (cnt == lim) begin
        cnt <= '0;
        q   <= ~q;
        ph  <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (clear)
    ph <= PH_LAST);
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_pkg::*;
#(
  parameter int SCAN_BITS  = SCAN_W,
  parameter int CHAIN_BITS = CHAIN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 use_primary,
  input  logic                 pri_tick,
  input  logic                 alt_clk,
  input  logic                 pass_in,
  input  logic [3:0]           rate_sel,
  output logic                 rate_out,
  output logic                 mclk_out,
  output logic [SCAN_BITS-1:0] scan_out
);
  logic tick, clear, alt_level, scan_wrap, frac_q, sel_sig;
  logic [CHAIN_BITS-1:0] chain;
  logic [NDIV-1:0] div_q;

  bclk_init u_init (
    .clk(clk), .rst(rst), .use_primary(use_primary), .pri_tick(pri_tick),
    .alt_clk(alt_clk), .tick(tick), .clear(clear), .alt_level(alt_level)
  );

  bclk_scan #(.SCAN_W(SCAN_BITS), .CHAIN_W(CHAIN_BITS)) u_scan (
    .clk(clk), .clear(clear), .tick(tick),
    .scan_q(scan_out), .chain_q(chain), .wrap_tick(scan_wrap)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    bclk_toggle #(.HALF(DIV_HALF[g])) u_div (
      .clk(clk), .clear(clear),
      .en(DIV_SCAN[g] ? scan_wrap : tick),
      .q(div_q[g])
    );
  end

  bclk_frac #(.LONG(FRAC_LONG), .SHORT(FRAC_SHORT), .GROUP(FRAC_GROUP)) u_frac (
    .clk(clk), .clear(clear), .en(tick), .q(frac_q)
  );

  // div_q: [0]=50 [1]=200 [2]=110 [3]=134.5 ; chain bit k = 9600 >> k
  always_comb begin
    case (rate_sel_e'(rate_sel))
      SEL_B50:    sel_sig = div_q[0];
      SEL_B75:    sel_sig = chain[7];
      SEL_B134:   sel_sig = div_q[3];
      SEL_B200:   sel_sig = div_q[1];
      SEL_B600:   sel_sig = chain[4];
      SEL_B2400:  sel_sig = chain[2];
      SEL_B9600:  sel_sig = chain[0];
      SEL_B4800:  sel_sig = chain[1];
      SEL_B1800:  sel_sig = frac_q;
      SEL_B1200:  sel_sig = chain[3];
      SEL_B2400B: sel_sig = chain[2];
      SEL_B300:   sel_sig = chain[5];
      SEL_B150:   sel_sig = chain[6];
      SEL_B110:   sel_sig = div_q[2];
      default:    sel_sig = pass_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      rate_out <= 1'b0;
      mclk_out <= 1'b0;
    end else begin
      mclk_out <= tick;
      if (tick) rate_out <= sel_sig;
    end
  end

  // R2
  scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(scan_out));
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(rate_out));
  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (use_primary && alt_level) |=> (scan_out == '0 && !mclk_out && !rate_out));
  // R9
  alt_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_primary && !alt_level) |=> $stable(scan_out));
endmodule

// File: tb/bclk_gen_test.sv
module bclk_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic use_primary = 1'b1, pri_tick = 1'b0, alt_clk = 1'b0, pass_in = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic rate_out, mclk_out;
  logic [2:0] scan_out;
  int vecs = 0, fails = 0, cyc = 0;

  bclk_gen uut (
    .clk(clk), .rst(rst), .use_primary(use_primary), .pri_tick(pri_tick),
    .alt_clk(alt_clk), .pass_in(pass_in), .rate_sel(rate_sel),
    .rate_out(rate_out), .mclk_out(mclk_out), .scan_out(scan_out)
  );

  always #10 clk = ~clk;

  // {select code, bit rate x10}
  localparam int unsigned VEC [14][2] = '{
    '{2, 500},   '{3, 750},   '{4, 1345},  '{5, 2000},  '{6, 6000},
    '{7, 24000}, '{8, 96000}, '{9, 48000}, '{10, 18000}, '{11, 12000},
    '{12, 24000}, '{13, 3000}, '{14, 1500}, '{15, 1100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles over three periods, first period length, high time of first period
  task automatic measure(output int per3, output int per1, output int hi);
    logic prev, r;
    int n;
    step(1);
    prev = rate_out;
    do begin
      step(1);
      r = rate_out;
      n = int'(r & ~prev);
      prev = r;
    end while (n == 0);
    per3 = 0; per1 = 0; hi = 0; n = 0;
    while (n < 3) begin
      if (n == 0 && prev) hi++;
      step(1);
      per3++;
      r = rate_out;
      if (r && !prev) begin
        n++;
        if (n == 1) per1 = per3;
      end
      prev = r;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(1'b0, "watchdog", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int per3, per1, hi, s;
    real expp, err;
    step(3);
    check(scan_out == 3'd0 && !mclk_out && !rate_out, "R1 reset state", {rate_out, mclk_out, scan_out}, 0);
    rst = 1'b0;
    step(1);
    check(scan_out == 3'd0 && !mclk_out && !rate_out, "R1 after release", {rate_out, mclk_out, scan_out}, 0);

    // R2 single tick, then idle, then nine more
    pri_tick = 1'b1; step(1);
    check(scan_out == 3'd1, "R2 scan after tick", scan_out, 1);
    check(mclk_out == 1'b1, "R2 mclk pulse", mclk_out, 1);
    pri_tick = 1'b0; step(1);
    check(mclk_out == 1'b0, "R2 mclk low without tick", mclk_out, 0);
    step(3);
    check(scan_out == 3'd1, "R2 scan holds", scan_out, 1);
    pri_tick = 1'b1; step(9); pri_tick = 1'b0; step(1);
    check(scan_out == 3'd2, "R2 scan wraps mod 8", scan_out, 2);

    // R3 / R4 pass-through codes
    rate_sel = 4'd0; pass_in = 1'b1; step(2);
    check(rate_out == 1'b0, "R4 no change without tick", rate_out, 0);
    pri_tick = 1'b1; step(1); pri_tick = 1'b0;
    check(rate_out == 1'b1, "R3 code 0 passes high", rate_out, 1);
    rate_sel = 4'd1; pass_in = 1'b0; pri_tick = 1'b1; step(1); pri_tick = 1'b0;
    check(rate_out == 1'b0, "R3 code 1 passes low", rate_out, 0);
    pass_in = 1'b1; step(3);
    check(rate_out == 1'b0, "R4 pass_in ignored between ticks", rate_out, 0);
    rate_sel = 4'd8; step(2);
    check(rate_out == 1'b0, "R4 rate_sel ignored between ticks", rate_out, 0);

    // R8 hold clear in primary mode
    pri_tick = 1'b1; alt_clk = 1'b1; step(6);
    check(scan_out == 3'd0 && !mclk_out && !rate_out, "R8 held clear", {rate_out, mclk_out, scan_out}, 0);
    alt_clk = 1'b0; step(5);
    check(scan_out == 3'd4, "R8 ticks resume", scan_out, 4);

    // R5 / R6 / R7 rate table
    for (int i = 0; i < 14; i++) begin
      rate_sel = 4'(VEC[i][0]);
      measure(per3, per1, hi);
      expp = 3.0 * 1536000.0 / real'(VEC[i][1]);
      err = (real'(per3) - expp) / expp;
      if (err < 0.0) err = -err;
      check(err <= 0.005, $sformatf("R5 code %0d period x3", VEC[i][0]), per3, int'(expp));
      check((2 * hi - per1) <= 1 && (per1 - 2 * hi) <= 1,
            $sformatf("R6 code %0d duty (high vs period)", VEC[i][0]), hi, per1 / 2);
      if (VEC[i][0] == 10) check(per3 == 256, "R6 1800 three periods", per3, 256);
      if (VEC[i][0] == 8)  check(per1 == 16, "R7 9600 period", per1, 16);
    end

    // R9 alternate mode
    s = int'(scan_out);
    use_primary = 1'b0; step(4);
    check(int'(scan_out) == s, "R9 pri_tick ignored", scan_out, s);
    alt_clk = 1'b1; step(4);
    check(scan_out == 3'd0, "R9 first high clears", scan_out, 0);
    alt_clk = 1'b0; step(2); alt_clk = 1'b1; step(3);
    check(scan_out == 3'd1, "R9 rising edge ticks", scan_out, 1);
    alt_clk = 1'b0; step(2); alt_clk = 1'b1; step(3);
    check(scan_out == 3'd2, "R9 second rising edge", scan_out, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule